// File: doc/BRIEF.md
# Collision-Line Heartbeat Generator for 10 Mb/s Twisted Pair

This block drives the collision output of a 10 Mb/s twisted-pair transmit path. After every frame ends, it raises collision for a short fixed window after a fixed quiet gap. The MAC uses this window as a liveness heartbeat for the collision detector. The real collision indication from the line reaches the same output at all times, through a combinational OR.

The heartbeat starts only when several conditions hold. The port must be in 10 Mb/s twisted-pair mode. Repeater operation must be off, and the local disable bit must be clear. No line collision may have been seen during the frame that just ended. If a new frame starts while a heartbeat is still pending or still showing, that heartbeat is cancelled.

The gap and the window are parameters counted in clock cycles. By default each is one microsecond, worked out from the clock frequency parameter. All pins are plain level-sensitive control signals and no data moves through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `sqe_heartbeat_gen`

## Requirements
- R1: While reset is active and in the cycles after it is released, `col` equals `line_col`, and no heartbeat is pending.
- R2: The end of a frame is the first clock edge that samples `tx_en` low after sampling it high. The heartbeat on `col` first shows in the cycle after the DELAY_CYC-th clock edge that follows that edge.
- R3: The heartbeat keeps `col` high for exactly PULSE_CYC consecutive cycles, then lets it drop.
- R4: `col` is high in every cycle in which `line_col` is high, in the same cycle and with no register in the path.
- R5: If `line_col` was sampled high on any clock edge while `tx_en` was high in a frame, that frame produces no heartbeat.
- R6: If `repeater_en` is high at the edge where the frame ends, no heartbeat follows.
- R7: If `sqe_dis` is high at the edge where the frame ends, no heartbeat follows.
- R8: If `mode_10bt` is low at the edge where the frame ends, no heartbeat follows.
- R9: A rising edge of `tx_en` during the gap or during the window cancels the heartbeat. From the next cycle on, `col` follows `line_col` only.
- R10: The record of a collision within a frame clears when `tx_en` next rises. A clean frame that comes after a collided frame therefore gets its heartbeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| line_col | input | 1 | Collision detected on the line |
| mode_10bt | input | 1 | High when the port runs 10 Mb/s twisted pair |
| repeater_en | input | 1 | High in repeater operation; blocks the heartbeat |
| sqe_dis | input | 1 | Disables the heartbeat when high |
| col | output | 1 | Collision output: line collision OR heartbeat |

## Verification
Plain frames of several lengths, including a one-cycle frame, pin down the position of the gap and the width of the window. Frames that carry a collision in their middle and in their last high cycle are each followed by a clean frame. These tell apart the per-frame suppression and its clearing at the next frame start. Frames sent with each of the three gating inputs set separate the three enable conditions from one another. Frames that restart during the gap and during the window show that cancellation works. Line collisions placed in idle time and over a live heartbeat show that the OR path passes them straight through.

// File: rtl/sqe_pkg.sv
package sqe_pkg;
  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hb_state_e;
endpackage

// File: rtl/tx_edge_det.sv
module tx_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  output logic rise,
  output logic fall
);
  logic tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= tx_en;
  end

  assign rise = tx_en & ~tx_q;
  assign fall = ~tx_en & tx_q;
endmodule

// File: rtl/frame_col_trk.sv
module frame_col_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic rise,
  input  logic line_col,
  output logic col_seen
);
  // Collision memory for the current frame; restarts at each frame start.
  always_ff @(posedge clk) begin
    if (!rst_n)    col_seen <= 1'b0;
    else if (rise) col_seen <= line_col;
    else if (tx_en && line_col) col_seen <= 1'b1;
  end
endmodule

// File: rtl/sqe_timer.sv
module sqe_timer
  import sqe_pkg::*;
#(
  parameter int DELAY_CYC = 250,
  parameter int PULSE_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic active
);
  localparam int MAXC = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DLY_LD = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] PLS_LD = CW'(PULSE_CYC - 1);

  hb_state_e       st;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= HB_IDLE;
      cnt <= '0;
    end else if (abort) begin
      st  <= HB_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        HB_IDLE: if (start) begin
          st  <= HB_WAIT;
          cnt <= DLY_LD;
        end
        HB_WAIT: if (cnt == '0) begin
          st  <= HB_PULSE;
          cnt <= PLS_LD;
        end else begin
          cnt <= cnt - 1'b1;
        end
        HB_PULSE: if (cnt == '0) begin
          st <= HB_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= HB_IDLE;
      endcase
    end
  end

  assign active = (st == HB_PULSE);
endmodule

// File: rtl/sqe_heartbeat_gen.sv
module sqe_heartbeat_gen #(
  parameter int CLK_HZ    = 250_000_000,
  parameter int DELAY_CYC = CLK_HZ / 1_000_000,
  parameter int PULSE_CYC = CLK_HZ / 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic line_col,
  input  logic mode_10bt,
  input  logic repeater_en,
  input  logic sqe_dis,
  output logic col
);
  logic tx_rise, tx_fall, col_seen, hb_start, hb_act, hb_allowed;

  tx_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
    .rise(tx_rise), .fall(tx_fall)
  );

  frame_col_trk u_trk (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rise(tx_rise),
    .line_col(line_col), .col_seen(col_seen)
  );

  assign hb_allowed = mode_10bt & ~repeater_en & ~sqe_dis;
  assign hb_start   = tx_fall & hb_allowed & ~col_seen;

  sqe_timer #(.DELAY_CYC(DELAY_CYC), .PULSE_CYC(PULSE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(hb_start), .abort(tx_rise),
    .active(hb_act)
  );

  assign col = hb_act | line_col;
endmodule

// File: rtl/sqe_heartbeat_chk.sv
module sqe_heartbeat_chk #(
  parameter int DELAY_CYC = 250,
  parameter int PULSE_CYC = 250
) (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic line_col,
  input logic mode_10bt,
  input logic repeater_en,
  input logic sqe_dis,
  input logic col,
  input logic hb_act
);
  localparam int GW = $clog2(DELAY_CYC + PULSE_CYC + 2);
  localparam logic [GW-1:0] GMAX = '1;
  localparam int RW = $clog2(PULSE_CYC + 2);
  localparam logic [RW-1:0] RMAX = '1;

  logic          ptx, fcol, gate_ok, clean;
  logic [GW-1:0] gap;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptx <= 1'b0; fcol <= 1'b0; gate_ok <= 1'b0; clean <= 1'b0;
      gap <= GMAX; run <= '0;
    end else begin
      ptx <= tx_en;
      if (tx_en && !ptx)          fcol <= line_col;
      else if (tx_en && line_col) fcol <= 1'b1;
      if (ptx && !tx_en) begin
        gap     <= '0;
        gate_ok <= mode_10bt && !repeater_en && !sqe_dis;
        clean   <= !fcol;
      end else if (gap != GMAX) begin
        gap <= gap + 1'b1;
      end
      if (!hb_act)         run <= '0;
      else if (run != RMAX) run <= run + 1'b1;
    end
  end

  assert_line_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    line_col |-> col);

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !hb_act);

  assert_gap_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hb_act) |-> (gap == GW'(DELAY_CYC)));

  assert_window_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RW'(PULSE_CYC));

  assert_no_hb_after_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hb_act) |-> clean);

  // Covers R7 and R8 as well: all three gating inputs meet in gate_ok.
  assert_gated_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hb_act) |-> gate_ok);

  assert_abort_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !ptx) |=> !hb_act);
endmodule

bind sqe_heartbeat_gen sqe_heartbeat_chk #(
  .DELAY_CYC(DELAY_CYC), .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .line_col(line_col),
  .mode_10bt(mode_10bt), .repeater_en(repeater_en), .sqe_dis(sqe_dis),
  .col(col), .hb_act(hb_act)
);

// File: tb/sqe_heartbeat_gen_bench.sv
module sqe_heartbeat_gen_bench;
  localparam int D = 6;
  localparam int P = 4;

  typedef struct { bit exp; string req; } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b0, line_col = 1'b0, mode_10bt = 1'b1, repeater_en = 1'b0, sqe_dis = 1'b0;
  logic col;

  int checks = 0, errors = 0;
  bit done = 0;
  item_t exp_q[$];
  string cur_req = "R1";

  // reference state built from the requirements
  bit m_txq = 0, m_cflag = 0, m_armed = 0;
  int m_age = 0;
  bit p_tx = 0, p_lc = 0, p_en = 1;
  bit g_md = 1, g_rp = 0, g_ds = 0;

  always #2 clk = ~clk;

  sqe_heartbeat_gen #(.DELAY_CYC(D), .PULSE_CYC(P)) u_sqe_heartbeat_gen (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .line_col(line_col),
    .mode_10bt(mode_10bt), .repeater_en(repeater_en), .sqe_dis(sqe_dis),
    .col(col)
  );

  task automatic step(input bit tx, input bit lc);
    item_t it;
    @(negedge clk);
    if (!m_txq && p_tx) begin m_armed = 0; m_cflag = p_lc; end
    else if (p_tx && p_lc) m_cflag = 1;
    if (m_txq && !p_tx) begin m_armed = p_en && !m_cflag; m_age = 0; end
    else if (m_armed) begin m_age++; if (m_age >= D + P) m_armed = 0; end
    m_txq = p_tx;
    tx_en = tx; line_col = lc;
    mode_10bt = g_md; repeater_en = g_rp; sqe_dis = g_ds;
    p_tx = tx; p_lc = lc; p_en = g_md && !g_rp && !g_ds;
    it.exp = (m_armed && m_age >= D) || lc;
    it.req = cur_req;
    exp_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  // frame of len cycles; collision at high cycle col_at (-1: none)
  task automatic frame(input int len, input int col_at);
    for (int i = 0; i < len; i++) step(1, i == col_at);
  endtask

  // monitor: scoreboard pop and compare
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (col !== it.exp) begin
          errors++;
          $display("FAIL %s: col=%0b expected %0b at %0t", it.req, col, it.exp, $time);
        end
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    checks++;  // R1: output quiet in reset
    if (col !== 1'b0) begin errors++; $display("FAIL R1: col=%0b expected 0 in reset", col); end
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; idle(4);

    cur_req = "R2"; frame(8, -1); idle(14);
    cur_req = "R3"; frame(3, -1); idle(14);
    cur_req = "R2"; frame(1, -1); idle(14);

    cur_req = "R4"; step(0, 1); step(0, 0); step(0, 1); idle(2);
    frame(5, -1); idle(5); step(0, 1); step(0, 1); idle(10);

    cur_req = "R5"; frame(8, 3); idle(14);
    cur_req = "R10"; frame(6, -1); idle(14);
    cur_req = "R5"; frame(6, 5); idle(14);
    cur_req = "R10"; frame(4, -1); idle(14);

    cur_req = "R6"; g_rp = 1; frame(6, -1); idle(14); g_rp = 0;
    cur_req = "R7"; g_ds = 1; frame(6, -1); idle(14); g_ds = 0;
    cur_req = "R8"; g_md = 0; frame(6, -1); idle(14); g_md = 1;

    cur_req = "R9"; frame(5, -1); idle(3); frame(4, -1); idle(14);
    frame(5, -1); idle(D + 2); frame(3, -1); idle(14);

    idle(2);
    @(negedge clk); #2;
    done = 1;
    summary();
    $finish;
  end
endmodule